// File: doc/BRIEF.md
# Symmetric Scaler Coefficient Kernel Fetcher

This block keeps one 32-tap scaling filter kernel in a small word-addressed store and hands single signed coefficients to a filter datapath. Every stored word carries three 9-bit two's-complement coefficients. The 11 stored words hold the kernel in two parts. The lower part runs upward from tap 0, and one slot in it is left as padding. The upper part runs downward, and inside each of its words the coefficient order is reversed. Because of this layout, a linear-phase kernel can be completed by copying whole words in mirror order.

Software can load the store one word at a time through a host write port. It can also hand the six words of a half-kernel to a built-in expander, which writes all 11 stored words, one per cycle, and then signals completion. On the read side the datapath gives a tap index from 0 to 31. One cycle later the block returns that tap's coefficient, sign-extended. The block itself works out which word and which slot hold the tap.

Top module: `kernel_fetch`

## Requirements
- R1: Stored word slot s (s = 0, 1, 2) holds a 9-bit two's-complement coefficient in bits [9s+8 : 9s].
- R2: Taps 0 to 16 are read from word t/3, slot t mod 3 (integer division). Word 5 slot 2 is padding and no tap reads it.
- R3: Taps 17 to 31 are read from words 6 to 10. The tap number rises as you go from word 6 slot 2, down to word 6 slot 0, then on to word 7 slot 2, and so on up to word 10 slot 0, which holds tap 31.
- R4: When the read enable is high at a clock edge, the coefficient and a high valid flag appear after that edge. When the read enable is low, the valid flag is low and the coefficient output keeps its last value.
- R5: Bits 31 to 27 of a stored word have no effect on any coefficient that is read.
- R6: A host write to word address 0 to 10 replaces that word. A host write to address 11 to 15 changes nothing.
- R7: After an expansion, stored word i holds half-kernel word i for i = 0 to 5, and half-kernel word 10 - i for i = 6 to 10. Bits 31 to 27 are zero. Half-kernel word j is taken from bits [32j+31 : 32j] of the loader input.
- R8: The start request is accepted at an edge. The busy flag is then high after that edge and after the next 10 edges. The done flag is high for exactly one cycle, after the 11th edge, which is the same edge at which busy falls.
- R9: While busy is high, host writes are ignored and a further start request neither restarts nor extends the expansion.
- R10: After reset, every stored word is zero, every tap reads as 0, and the valid, busy and done flags are low.
- R11: When a linear-phase half-kernel is expanded, with word 5 holding coefficient 15 twice followed by a zero, tap t and tap 31 - t read the same value, and tap 16 equals tap 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host word write strobe |
| wr_addr | input | 4 | Host write word address |
| wr_data | input | 32 | Host write packed word |
| rd_en | input | 1 | Coefficient read request |
| rd_tap | input | 5 | Tap index 0 to 31 |
| coef | output | 9 | Signed coefficient, registered |
| coef_vld | output | 1 | Coefficient valid, one cycle after the request |
| ld_start | input | 1 | Start half-kernel expansion |
| ld_half | input | 192 | Six packed half-kernel words, word j at bits [32j+31:32j] |
| ld_busy | output | 1 | Expansion in progress |
| ld_done | output | 1 | One-cycle pulse when all 11 words are written |

## Verification
The hardest case to reach from the ports is a host write, or a second start request, that arrives while the expander is partway through its eleven writes. The bench causes both in the middle of an expansion. It raises a host write to a word that has already been expanded, and a restart a few cycles later. It then checks, cycle by cycle, that busy and done keep the original eleven-cycle timing, and that the final contents match the mirrored half-kernel and not the host data. The reference kernel is then read back across all 32 taps, which checks the reversed order inside each upper word against the symmetry of the kernel.

// File: rtl/kernel_fetch_pkg.sv
package kernel_fetch_pkg;

  typedef enum logic {
    EXP_IDLE = 1'b0,
    EXP_RUN  = 1'b1
  } exp_state_e;

  // Source half-kernel word for stored word idx: first half direct, rest mirrored.
  function automatic int mirror_src(input int idx, input int half_words);
    int kwords;
    kwords = 2 * half_words - 1;
    if (idx < half_words) return idx;
    return kwords - 1 - idx;
  endfunction

endpackage

// File: rtl/kernel_store.sv
module kernel_store #(
  parameter int WORD_W = 32,
  parameter int KWORDS = 11,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [KWORDS];
  logic              addr_ok;

  assign addr_ok = (int'(waddr) < KWORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < KWORDS; i++) mem[i] <= '0;
    end else if (we && addr_ok) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = (int'(raddr) < KWORDS) ? mem[raddr] : '0;

endmodule

// File: rtl/kernel_expander.sv
module kernel_expander
  import kernel_fetch_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int HALF_WORDS = 6,
  parameter int PAY        = 27,
  parameter int KWORDS     = 11,
  parameter int AW         = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [HALF_WORDS*WORD_W-1:0] half_in,
  output logic                         busy,
  output logic                         done,
  output logic                         ex_we,
  output logic [AW-1:0]                ex_waddr,
  output logic [WORD_W-1:0]            ex_wdata
);

  localparam logic [WORD_W-1:0] PAY_MASK = WORD_W'((64'(1) << PAY) - 1);

  exp_state_e        state_q;
  logic [AW-1:0]     idx_q;
  logic [WORD_W-1:0] half_q [HALF_WORDS];
  logic              last_word;
  logic              accept;

  assign accept    = start && (state_q == EXP_IDLE);
  assign last_word = (idx_q == AW'(KWORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EXP_IDLE;
      idx_q   <= '0;
      done    <= 1'b0;
      for (int j = 0; j < HALF_WORDS; j++) half_q[j] <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state_q <= EXP_RUN;
        idx_q   <= '0;
        for (int j = 0; j < HALF_WORDS; j++) half_q[j] <= half_in[j*WORD_W +: WORD_W];
      end else if (state_q == EXP_RUN) begin
        idx_q <= idx_q + 1'b1;
        if (last_word) begin
          state_q <= EXP_IDLE;
          done    <= 1'b1;
        end
      end
    end
  end

  assign busy     = (state_q == EXP_RUN);
  assign ex_we    = busy;
  assign ex_waddr = idx_q;
  assign ex_wdata = half_q[mirror_src(int'(idx_q), HALF_WORDS)] & PAY_MASK;

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: done coincides with the end of busy
  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R9: an expansion in progress is not cut short or restarted
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_word) |=> (busy && idx_q == $past(idx_q) + 1'b1));
  // R7: written words carry zero in the unused top bits
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ex_we |-> ((ex_wdata & ~PAY_MASK) == '0));

endmodule

// File: rtl/coef_reader.sv
module coef_reader #(
  parameter int WORD_W   = 32,
  parameter int COEF_W   = 9,
  parameter int PER_WORD = 3,
  parameter int KWORDS   = 11,
  parameter int TAPS     = 32,
  parameter int ASC      = 17,
  parameter int AW       = 4,
  parameter int TAP_W    = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [TAP_W-1:0]         rd_tap,
  output logic [AW-1:0]            raddr,
  input  logic [WORD_W-1:0]        rdata,
  output logic signed [COEF_W-1:0] coef,
  output logic                     coef_vld
);

  localparam int PAY = PER_WORD * COEF_W;

  function automatic int tap_word(input int t);
    if (t < ASC) return t / PER_WORD;
    return KWORDS - 1 - (TAPS - 1 - t) / PER_WORD;
  endfunction

  function automatic int tap_slot(input int t);
    if (t < ASC) return t % PER_WORD;
    return (TAPS - 1 - t) % PER_WORD;
  endfunction

  logic [COEF_W-1:0] field;
  logic              unused_top;
  int                slot;

  assign raddr      = AW'(tap_word(int'(rd_tap)));
  assign slot       = tap_slot(int'(rd_tap));
  assign field      = rdata[slot*COEF_W +: COEF_W];
  assign unused_top = ^rdata[WORD_W-1:PAY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef     <= '0;
      coef_vld <= 1'b0;
    end else begin
      coef_vld <= rd_en;
      if (rd_en) coef <= $signed(field);
    end
  end

  // R4: a request yields valid data on the next cycle
  p_vld_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> coef_vld);
  // R4: no request, no valid
  p_vld_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !coef_vld);
  // R4: output holds when not requested
  p_coef_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(coef));

endmodule

// File: rtl/kernel_fetch.sv
module kernel_fetch #(
  parameter int WORD_W     = 32,
  parameter int COEF_W     = 9,
  parameter int PER_WORD   = 3,
  parameter int HALF_WORDS = 6,
  localparam int KWORDS    = 2 * HALF_WORDS - 1,
  localparam int ASC       = HALF_WORDS * PER_WORD - 1,
  localparam int TAPS      = ASC + (HALF_WORDS - 1) * PER_WORD,
  localparam int AW        = $clog2(KWORDS),
  localparam int TAP_W     = $clog2(TAPS),
  localparam int PAY       = PER_WORD * COEF_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [WORD_W-1:0]            wr_data,
  input  logic                         rd_en,
  input  logic [TAP_W-1:0]             rd_tap,
  output logic signed [COEF_W-1:0]     coef,
  output logic                         coef_vld,
  input  logic                         ld_start,
  input  logic [HALF_WORDS*WORD_W-1:0] ld_half,
  output logic                         ld_busy,
  output logic                         ld_done
);

  logic              ex_we;
  logic [AW-1:0]     ex_waddr;
  logic [WORD_W-1:0] ex_wdata;
  logic              st_we;
  logic [AW-1:0]     st_waddr;
  logic [WORD_W-1:0] st_wdata;
  logic [AW-1:0]     rd_word;
  logic [WORD_W-1:0] rd_data;
  logic              host_dropped;

  kernel_expander #(
    .WORD_W(WORD_W), .HALF_WORDS(HALF_WORDS), .PAY(PAY), .KWORDS(KWORDS), .AW(AW)
  ) u_exp (
    .clk(clk), .rst_n(rst_n), .start(ld_start), .half_in(ld_half),
    .busy(ld_busy), .done(ld_done),
    .ex_we(ex_we), .ex_waddr(ex_waddr), .ex_wdata(ex_wdata)
  );

  // Expander owns the write port while it runs; host strobes are dropped.
  assign host_dropped = ld_busy && wr_en;
  assign st_we        = ld_busy ? ex_we    : wr_en;
  assign st_waddr     = ld_busy ? ex_waddr : wr_addr;
  assign st_wdata     = ld_busy ? ex_wdata : wr_data;

  kernel_store #(.WORD_W(WORD_W), .KWORDS(KWORDS), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
    .raddr(rd_word), .rdata(rd_data)
  );

  coef_reader #(
    .WORD_W(WORD_W), .COEF_W(COEF_W), .PER_WORD(PER_WORD), .KWORDS(KWORDS),
    .TAPS(TAPS), .ASC(ASC), .AW(AW), .TAP_W(TAP_W)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_tap(rd_tap),
    .raddr(rd_word), .rdata(rd_data), .coef(coef), .coef_vld(coef_vld)
  );

  // R9: a dropped host write never reaches the store with host data
  p_host_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_dropped |-> (st_waddr == ex_waddr && st_wdata == ex_wdata));
  // R6: reads never address beyond the stored kernel
  p_rd_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_word) < KWORDS);

endmodule

// File: tb/tb_kernel_fetch.sv
module tb_kernel_fetch;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         rd_en = 1'b0;
  logic [4:0]   rd_tap = '0;
  logic signed [8:0] coef;
  logic         coef_vld;
  logic         ld_start = 1'b0;
  logic [191:0] ld_half = '0;
  logic         ld_busy;
  logic         ld_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [31:0] mdl [11];
  int wsel [32];
  int ssel [32];
  int refc [18];

  always #2 clk = ~clk;

  kernel_fetch dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_tap(rd_tap), .coef(coef), .coef_vld(coef_vld),
    .ld_start(ld_start), .ld_half(ld_half), .ld_busy(ld_busy), .ld_done(ld_done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_tap(input int t);
    logic [8:0] f;
    f = mdl[wsel[t]][ssel[t]*9 +: 9];
    return int'($signed(f));
  endfunction

  function automatic logic [31:0] pack3(input int a, input int b, input int c, input logic [4:0] hi);
    return {hi, 9'(c), 9'(b), 9'(a)};
  endfunction

  task automatic host_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (addr < 11) mdl[addr] = data;
  endtask

  task automatic read_tap(input int t, output int val, output int vld);
    @(negedge clk);
    rd_en = 1'b1; rd_tap = 5'(t);
    @(negedge clk);
    rd_en = 1'b0;
    val = int'(coef); vld = int'(coef_vld);
  endtask

  task automatic test_reset();
    int v, k;
    check("R10 valid after reset", int'(coef_vld), 0);
    check("R10 busy after reset", int'(ld_busy), 0);
    check("R10 done after reset", int'(ld_done), 0);
    for (int t = 0; t < 32; t += 7) begin
      read_tap(t, v, k);
      check("R10 tap zero after reset", v, 0);
    end
  endtask

  task automatic test_ascending();
    int v, k;
    host_write(0, pack3(-256, 255, -1, 5'h1f));
    host_write(1, pack3(100, -100, 7, 5'h00));
    host_write(2, pack3(1, 2, 3, 5'h0a));
    host_write(3, pack3(-3, -4, -5, 5'h15));
    host_write(4, pack3(60, -70, 80, 5'h11));
    host_write(5, pack3(127, -128, 99, 5'h02));
    for (int t = 0; t < 17; t++) begin
      read_tap(t, v, k);
      check("R1 R2 ascending tap", v, model_tap(t));
      check("R4 valid on read", k, 1);
    end
  endtask

  task automatic test_descending();
    int v, k;
    host_write(6, pack3(11, -12, 13, 5'h03));
    host_write(7, pack3(-21, 22, -23, 5'h1c));
    host_write(8, pack3(31, 32, -33, 5'h00));
    host_write(9, pack3(-255, 200, 150, 5'h07));
    host_write(10, pack3(41, -42, 43, 5'h19));
    for (int t = 17; t < 32; t++) begin
      read_tap(t, v, k);
      check("R3 descending tap", v, model_tap(t));
    end
    read_tap(31, v, k);
    check("R3 tap31 is word10 slot0", v, 41);
    read_tap(17, v, k);
    check("R3 tap17 is word6 slot2", v, 13);
  endtask

  task automatic test_upper_bits();
    int a [3];
    int v, k;
    host_write(3, pack3(-77, 66, -55, 5'h00));
    for (int s = 0; s < 3; s++) read_tap(9 + s, a[s], k);
    host_write(3, pack3(-77, 66, -55, 5'h1f));
    for (int s = 0; s < 3; s++) begin
      read_tap(9 + s, v, k);
      check("R5 upper bits ignored", v, a[s]);
    end
  endtask

  task automatic test_range();
    int v, k;
    for (int a = 11; a < 16; a++) host_write(a, 32'h05ab_cdef);
    for (int t = 0; t < 32; t++) begin
      read_tap(t, v, k);
      check("R6 out-of-range write ignored", v, model_tap(t));
    end
  endtask

  task automatic test_latency();
    int held;
    @(negedge clk);
    rd_en = 1'b1; rd_tap = 5'd0;
    @(negedge clk);
    check("R4 valid one cycle later", int'(coef_vld), 1);
    check("R4 data one cycle later", int'(coef), model_tap(0));
    held = int'(coef);
    rd_en = 1'b0; rd_tap = 5'd4;
    @(negedge clk);
    check("R4 valid drops without request", int'(coef_vld), 0);
    check("R4 coef holds without request", int'(coef), held);
  endtask

  task automatic run_expand(input logic [31:0] hw [6], input bit disturb);
    for (int j = 0; j < 6; j++) ld_half[j*32 +: 32] = hw[j];
    @(negedge clk);
    ld_start = 1'b1;
    @(negedge clk);
    ld_start = 1'b0;
    for (int n = 0; n <= 12; n++) begin
      if (n < 11) begin
        check("R8 busy during expansion", int'(ld_busy), 1);
        check("R8 no early done", int'(ld_done), 0);
      end else if (n == 11) begin
        check("R8 busy falls after 11 writes", int'(ld_busy), 0);
        check("R8 done pulse", int'(ld_done), 1);
      end else begin
        check("R8 done lasts one cycle", int'(ld_done), 0);
      end
      wr_en    = disturb && (n == 3);
      wr_addr  = 4'd1;
      wr_data  = 32'h0000_01ff;
      ld_start = disturb && (n == 5);
      @(negedge clk);
    end
    wr_en = 1'b0; ld_start = 1'b0;
    for (int i = 0; i < 11; i++)
      mdl[i] = (i < 6 ? hw[i] : hw[10 - i]) & 32'h07ff_ffff;
  endtask

  task automatic test_reference();
    logic [31:0] hw [6];
    int v, k, w, idx;
    for (int j = 0; j < 6; j++)
      hw[j] = pack3(refc[3*j], refc[3*j+1], refc[3*j+2], 5'h15);
    run_expand(hw, 1'b1);
    for (int t = 0; t < 32; t++) begin
      read_tap(t, v, k);
      idx = (t < 16) ? t : (t == 16 ? 15 : 31 - t);
      check("R11 reference kernel tap", v, refc[idx]);
      check("R7 R9 expanded contents", v, model_tap(t));
    end
    read_tap(3, v, k);
    read_tap(28, w, k);
    check("R11 mirror pair 3/28", w, v);
  endtask

  task automatic test_expand_generic();
    logic [31:0] hw [6];
    int v, k;
    for (int j = 0; j < 6; j++)
      hw[j] = pack3(17 * j - 40, -9 * j + 3, 31 * j - 77, 5'(j + 9));
    run_expand(hw, 1'b0);
    for (int t = 0; t < 32; t++) begin
      read_tap(t, v, k);
      check("R7 expanded mirror contents", v, model_tap(t));
    end
  endtask

  initial begin
    int k;
    int c16 [16] = '{0, -2, -6, -8, -10, -8, -3, 2, 18, 50, 82, 119, 155, 187, 213, 227};
    for (int i = 0; i < 16; i++) refc[i] = c16[i];
    refc[16] = c16[15];
    refc[17] = 0;
    for (int p = 0; p < 17; p++) begin wsel[p] = p / 3; ssel[p] = p % 3; end
    k = 17;
    for (int w = 6; w < 11; w++)
      for (int s = 2; s >= 0; s--) begin wsel[k] = w; ssel[k] = s; k++; end
    for (int i = 0; i < 11; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_ascending();
    test_descending();
    test_upper_bits();
    test_range();
    test_latency();
    test_reference();
    test_expand_generic();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule